// File: doc/BRIEF.md
# Secure Debug Configuration Register

This block holds a 32-bit configuration word that sets how self-hosted debug, trace and the performance counters behave in the secure world. It sits behind a coprocessor-style port: each request carries a read/write flag, the privilege level of the requester, the security state, and a few qualifiers that describe how the hypervisor and the top level are configured. The block then rules on the access. It either completes it, reports it as undefined, or raises a trap to a higher level with a syndrome class. Only a completed write changes the stored word.

Reserved bits and the fields of features that a parameter marks absent read as zero and ignore writes. Each field has its own cold-reset value. A hardware lock pin blocks writes from the top level while the requester is in secure state. The register's contents go out on a parallel bus to the debug, trace and counter logic that uses them.

Top module: `seccfg_reg`

## Requirements
- R1: After reset the stored word has bit 28 (multithreaded counter enable) at 1 when that feature is present. Bit 27 (comms-channel trap) takes the parameter `COMMS_TRAP_RST` when its feature is present. Every other bit is 0, so with default parameters the word is 0x1000_0000.
- R2: Only bits 28, 27, 23, 21, 20, 19, 18, 17, 15 and 14 can hold a 1. With all features present the writable mask is 0x18BE_C000. A field whose feature parameter is 0 reads 0 and ignores writes.
- R3: A request at privilege 0 (user) or 2 (hypervisor) completes as undefined. The privilege code is 0 user, 1 kernel, 2 hypervisor, 3 top.
- R4: A kernel request with the hypervisor enabled and its T1 trap bit set traps to the hypervisor. The trap target is 01 when the hypervisor runs 64-bit and 10 when it runs 32-bit. This rule has top priority.
- R5: Otherwise, a kernel request traps with target 01 when the hypervisor runs 64-bit, NS is 0 and EEL2 is 1.
- R6: Otherwise, a kernel request traps with target 11 when the top level runs 64-bit and NS is 0. Any other kernel request is undefined.
- R7: The syndrome output is 0x03 on every trap and 0x00 at all other times. The target is 00 when there is no trap.
- R8: A top-level read completes and returns the stored word on `rsp_rdata`. The read data bus is 0 for every other result.
- R9: A top-level write is undefined when NS is 0 and `wr_lock` is 1. Otherwise it completes and stores the write data, masked as in R2.
- R10: The result outputs are registered one cycle after `req_valid` is sampled, and exactly one of ok, undef and trap is set. In a cycle with no request all three are 0.
- R11: A request that is undefined or trapped, and any read, leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 2 | Requester privilege: 0 user, 1 kernel, 2 hypervisor, 3 top |
| req_wdata | input | 32 | Write data |
| sec_ns | input | 1 | Non-secure state bit |
| sec_eel2 | input | 1 | Secure hypervisor enable bit |
| hyp_enabled | input | 1 | Hypervisor is enabled for the current state |
| hyp_is64 | input | 1 | Hypervisor runs 64-bit |
| hyp_t1 | input | 1 | Hypervisor trap bit for this register group |
| top_is64 | input | 1 | Top level runs 64-bit |
| wr_lock | input | 1 | Hardware write lock, effective in secure state |
| access_ok | output | 1 | Access completed |
| access_undef | output | 1 | Access is undefined |
| trap_valid | output | 1 | Access traps |
| trap_target | output | 2 | 00 none, 01 hypervisor system trap, 10 hypervisor trap (32-bit), 11 top level |
| trap_syndrome | output | 8 | Syndrome class on a trap |
| rsp_rdata | output | 32 | Read data for a completed read |
| cfg_value | output | 32 | Current stored word, to the consumers |

## Verification
Every verdict, its target and syndrome, and the read data appear one clock edge after the request is sampled. The stored word on `cfg_value` changes on that same edge. The bench drives a request on a falling edge and reads all outputs on the next falling edge, once the single register stage has updated, and compares them with a model evaluated before the edge. Idle cycles are checked the same way: all result outputs must be clear one edge after `req_valid` drops.

// File: rtl/seccfg_pkg.sv
package seccfg_pkg;

  localparam int REG_W  = 32;
  localparam int SYND_W = 8;
  localparam int TGT_W  = 2;

  localparam logic [SYND_W-1:0] SYND_TRAP = 8'h03;

  // field positions: the consumers decode these, so they are fixed
  localparam int B_MT_EN    = 28;
  localparam int B_COMMS_TR = 27;
  localparam int B_SCYC_DIS = 23;
  localparam int B_XPMU_DIS = 21;
  localparam int B_XDBG_DIS = 20;
  localparam int B_TFLT_TR  = 19;
  localparam int B_STRC_EN  = 18;
  localparam int B_SCNT_EN  = 17;
  localparam int B_SPDBG_LO = 14;
  localparam int B_SPDBG_HI = 15;

  typedef enum logic [1:0] {
    PRIV_USER   = 2'd0,
    PRIV_KERNEL = 2'd1,
    PRIV_HYP    = 2'd2,
    PRIV_TOP    = 2'd3
  } priv_e;

  typedef enum logic [TGT_W-1:0] {
    TGT_NONE    = 2'b00,
    TGT_HYP_SYS = 2'b01,
    TGT_HYP_32  = 2'b10,
    TGT_TOP     = 2'b11
  } trap_tgt_e;

  typedef struct packed {
    logic      ok;
    logic      undef;
    logic      trap;
    trap_tgt_e tgt;
  } access_res_t;

  // writable bits, given which features exist
  function automatic logic [REG_W-1:0] field_mask(bit has_mt, bit has_fgt,
                                                  bit has_pmu, bit has_ccd,
                                                  bit has_trf);
    logic [REG_W-1:0] m;
    m = '0;
    m[B_MT_EN]    = has_mt;
    m[B_COMMS_TR] = has_fgt;
    m[B_SCYC_DIS] = has_pmu & has_ccd;
    m[B_XPMU_DIS] = has_pmu;
    m[B_XDBG_DIS] = 1'b1;
    m[B_TFLT_TR]  = has_trf;
    m[B_STRC_EN]  = has_trf;
    m[B_SCNT_EN]  = has_pmu;
    m[B_SPDBG_HI] = 1'b1;
    m[B_SPDBG_LO] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] field_reset(bit has_mt, bit has_fgt,
                                                   bit has_pmu, bit has_ccd,
                                                   bit has_trf, bit comms_rst);
    logic [REG_W-1:0] r;
    r = '0;
    r[B_MT_EN]    = 1'b1;
    r[B_COMMS_TR] = comms_rst;
    return r & field_mask(has_mt, has_fgt, has_pmu, has_ccd, has_trf);
  endfunction

  // verdict for one access; the kernel chain is checked in priority order
  function automatic access_res_t decide_access(priv_e priv, logic wr,
      logic ns, logic eel2, logic hyp_en, logic hyp64, logic t1,
      logic top64, logic lock);
    access_res_t r;
    r = '{ok: 1'b0, undef: 1'b0, trap: 1'b0, tgt: TGT_NONE};
    unique case (priv)
      PRIV_KERNEL: begin
        if (hyp_en && t1) begin
          r.trap = 1'b1;
          r.tgt  = hyp64 ? TGT_HYP_SYS : TGT_HYP_32;
        end else if (hyp64 && !ns && eel2) begin
          r.trap = 1'b1;
          r.tgt  = TGT_HYP_SYS;
        end else if (top64 && !ns) begin
          r.trap = 1'b1;
          r.tgt  = TGT_TOP;
        end else begin
          r.undef = 1'b1;
        end
      end
      PRIV_TOP: begin
        if (wr && !ns && lock) r.undef = 1'b1;
        else                   r.ok    = 1'b1;
      end
      default: r.undef = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seccfg_access_check.sv
module seccfg_access_check
  import seccfg_pkg::*;
(
  input  logic        priv_is_kernel,
  input  logic        priv_is_top,
  input  logic [1:0]  priv,
  input  logic        wr,
  input  logic        ns,
  input  logic        eel2,
  input  logic        hyp_en,
  input  logic        hyp64,
  input  logic        t1,
  input  logic        top64,
  input  logic        lock,
  output access_res_t res
);

  always_comb begin
    res = decide_access(priv_e'(priv), wr, ns, eel2, hyp_en, hyp64, t1,
                        top64, lock);
  end

  // R10: one verdict per access; a trap always names a target
  always_comb begin
    a_r10_one_verdict: assert ($countones({res.ok, res.undef, res.trap}) == 1);
    a_r7_trap_has_target: assert (!res.trap || res.tgt != TGT_NONE);
    // R3: only kernel or top level requests can avoid an undefined result
    a_r3_low_priv_undef: assert (priv_is_kernel || priv_is_top || res.undef);
  end

endmodule

// File: rtl/seccfg_storage.sv
module seccfg_storage
  import seccfg_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK  = '1,
  parameter logic [REG_W-1:0] RESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);

  logic [REG_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= RESET;
    else if (wr_en) q_r <= wr_data & MASK;
  end

  assign q = q_r;

  // R11: contents change only on a committed write
  a_r11_hold_unless_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q_r));

  // R2: bits outside the mask never hold a 1
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q_r & ~MASK) == '0));

endmodule

// File: rtl/seccfg_reg.sv
module seccfg_reg
  import seccfg_pkg::*;
#(
  parameter bit HAS_MT         = 1'b1,
  parameter bit HAS_FGT        = 1'b1,
  parameter bit HAS_PMU        = 1'b1,
  parameter bit HAS_CCD        = 1'b1,
  parameter bit HAS_TRF        = 1'b1,
  parameter bit COMMS_TRAP_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_priv,
  input  logic [31:0]       req_wdata,
  input  logic              sec_ns,
  input  logic              sec_eel2,
  input  logic              hyp_enabled,
  input  logic              hyp_is64,
  input  logic              hyp_t1,
  input  logic              top_is64,
  input  logic              wr_lock,
  output logic              access_ok,
  output logic              access_undef,
  output logic              trap_valid,
  output logic [1:0]        trap_target,
  output logic [7:0]        trap_syndrome,
  output logic [31:0]       rsp_rdata,
  output logic [31:0]       cfg_value
);

  localparam logic [REG_W-1:0] MASK_C  =
    field_mask(HAS_MT, HAS_FGT, HAS_PMU, HAS_CCD, HAS_TRF);
  localparam logic [REG_W-1:0] RESET_C =
    field_reset(HAS_MT, HAS_FGT, HAS_PMU, HAS_CCD, HAS_TRF, COMMS_TRAP_RST);

  access_res_t      verdict;
  logic             commit_write;
  logic             commit_read;
  logic [REG_W-1:0] cfg_q;

  seccfg_access_check u_check (
    .priv_is_kernel (req_priv == PRIV_KERNEL),
    .priv_is_top    (req_priv == PRIV_TOP),
    .priv           (req_priv),
    .wr             (req_write),
    .ns             (sec_ns),
    .eel2           (sec_eel2),
    .hyp_en         (hyp_enabled),
    .hyp64          (hyp_is64),
    .t1             (hyp_t1),
    .top64          (top_is64),
    .lock           (wr_lock),
    .res            (verdict)
  );

  assign commit_write = req_valid && verdict.ok && req_write;
  assign commit_read  = req_valid && verdict.ok && !req_write;

  seccfg_storage #(.MASK(MASK_C), .RESET(RESET_C)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (commit_write),
    .wr_data (req_wdata),
    .q       (cfg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      access_ok     <= 1'b0;
      access_undef  <= 1'b0;
      trap_valid    <= 1'b0;
      trap_target   <= TGT_NONE;
      trap_syndrome <= '0;
      rsp_rdata     <= '0;
    end else begin
      access_ok     <= req_valid && verdict.ok;
      access_undef  <= req_valid && verdict.undef;
      trap_valid    <= req_valid && verdict.trap;
      trap_target   <= (req_valid && verdict.trap) ? verdict.tgt : TGT_NONE;
      trap_syndrome <= (req_valid && verdict.trap) ? SYND_TRAP : '0;
      rsp_rdata     <= commit_read ? cfg_q : '0;
    end
  end

  assign cfg_value = cfg_q;

  // R10: no request, no result
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(access_ok || access_undef || trap_valid));

  // R7: syndrome tied to the trap flag
  a_r7_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid ? (trap_syndrome == SYND_TRAP) : (trap_syndrome == '0));

  // R3: user and hypervisor requests come back undefined
  a_r3_undef_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_priv == PRIV_USER || req_priv == PRIV_HYP))
      |=> access_undef);

  // R9: a locked secure write is refused and the word holds
  a_r9_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_priv == PRIV_TOP && !sec_ns && wr_lock)
      |=> (access_undef && $stable(cfg_value)));

  // R4: enabled hypervisor with T1 set wins over later kernel rules
  a_r4_t1_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == PRIV_KERNEL && hyp_enabled && hyp_t1)
      |=> (trap_valid && trap_target != TGT_TOP));

endmodule

// File: tb/seccfg_reg_tb.sv
`timescale 1ns/1ps
module seccfg_reg_tb_top;

  localparam logic [31:0] EXP_MASK  = 32'h18BE_C000;
  localparam logic [31:0] EXP_RESET = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_priv = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        sec_ns = 1'b0, sec_eel2 = 1'b0, hyp_enabled = 1'b0;
  logic        hyp_is64 = 1'b0, hyp_t1 = 1'b0, top_is64 = 1'b0, wr_lock = 1'b0;
  logic        access_ok, access_undef, trap_valid;
  logic [1:0]  trap_target;
  logic [7:0]  trap_syndrome;
  logic [31:0] rsp_rdata, cfg_value;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] model_cfg;

  always #10 clk = ~clk;

  seccfg_reg dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_wdata(req_wdata), .sec_ns(sec_ns),
    .sec_eel2(sec_eel2), .hyp_enabled(hyp_enabled), .hyp_is64(hyp_is64),
    .hyp_t1(hyp_t1), .top_is64(top_is64), .wr_lock(wr_lock),
    .access_ok(access_ok), .access_undef(access_undef),
    .trap_valid(trap_valid), .trap_target(trap_target),
    .trap_syndrome(trap_syndrome), .rsp_rdata(rsp_rdata),
    .cfg_value(cfg_value)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // result code: {kind, target}; kind 0 ok, 1 undefined, 2 trap
  function automatic logic [3:0] expect_of(logic w, logic [1:0] p, logic ns,
      logic e2, logic he, logic h64, logic t, logic t64, logic lk);
    if (p == 2'd3) return (w && lk && !ns) ? 4'b0100 : 4'b0000;
    if (p != 2'd1) return 4'b0100;
    if (t && he)   return h64 ? 4'b1001 : 4'b1010;
    if (h64 && e2 && !ns) return 4'b1001;
    if (!ns && t64) return 4'b1011;
    return 4'b0100;
  endfunction

  task automatic access(string req, logic w, logic [1:0] p, logic [31:0] d,
      logic ns, logic e2, logic he, logic h64, logic t, logic t64, logic lk);
    logic [3:0]  e;
    logic [31:0] exp_rd;
    req_valid = 1'b1; req_write = w; req_priv = p; req_wdata = d;
    sec_ns = ns; sec_eel2 = e2; hyp_enabled = he; hyp_is64 = h64;
    hyp_t1 = t; top_is64 = t64; wr_lock = lk;
    e = expect_of(w, p, ns, e2, he, h64, t, t64, lk);
    exp_rd = (e[3:2] == 2'd0 && !w) ? model_cfg : 32'h0;
    if (e[3:2] == 2'd0 && w) model_cfg = d & EXP_MASK;
    @(negedge clk);
    chk(req, "ok",    {31'b0, access_ok},    {31'b0, e[3:2] == 2'd0});
    chk(req, "undef", {31'b0, access_undef}, {31'b0, e[3:2] == 2'd1});
    chk(req, "trap",  {31'b0, trap_valid},   {31'b0, e[3:2] == 2'd2});
    chk("R7", "target", {30'b0, trap_target}, {30'b0, e[1:0]});
    chk("R7", "syndrome", {24'b0, trap_syndrome},
        (e[3:2] == 2'd2) ? 32'h3 : 32'h0);
    chk("R8", "rdata", rsp_rdata, exp_rd);
    chk("R11", "cfg", cfg_value, model_cfg);
    req_valid = 1'b0;
  endtask

  task automatic idle_check();
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "idle", {29'b0, access_ok, access_undef, trap_valid}, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_cfg = EXP_RESET;
    chk("R1", "reset cfg", cfg_value, EXP_RESET);
    chk("R10", "reset outputs",
        {29'b0, access_ok, access_undef, trap_valid}, 32'h0);

    // R2 / R9: unlocked top-level write of all ones keeps only the mask
    access("R9", 1'b1, 2'd3, 32'hFFFF_FFFF, 1'b1, 0, 0, 0, 0, 1, 1'b1);
    chk("R2", "mask", cfg_value, EXP_MASK);
    // R8: read back
    access("R8", 1'b0, 2'd3, 32'h0, 1'b0, 0, 0, 0, 0, 1, 1'b1);
    // R9 / R11: locked secure write refused
    access("R9", 1'b1, 2'd3, 32'h0, 1'b0, 0, 0, 0, 0, 1, 1'b1);
    chk("R11", "locked hold", cfg_value, EXP_MASK);
    // R9: secure write with lock low completes
    access("R9", 1'b1, 2'd3, 32'h0000_C000, 1'b0, 0, 0, 0, 0, 1, 1'b0);
    chk("R9", "unlocked write", cfg_value, 32'h0000_C000);
    // R3: user read, hypervisor write
    access("R3", 1'b0, 2'd0, 32'h0, 1'b0, 0, 0, 0, 0, 1, 1'b0);
    access("R3", 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b1, 0, 0, 0, 0, 1, 1'b0);
    chk("R11", "hyp write hold", cfg_value, 32'h0000_C000);
    // R4: T1 with hypervisor 64-bit, then 32-bit
    access("R4", 1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 1, 1, 1, 1, 1, 1'b0);
    access("R4", 1'b0, 2'd1, 32'h0, 1'b0, 1, 1, 0, 1, 1, 1'b0);
    // R5: T1 set but hypervisor disabled, pair {NS,EEL2}=01
    access("R5", 1'b0, 2'd1, 32'h0, 1'b0, 1, 0, 1, 1, 1, 1'b0);
    // R6: falls through to the top-level trap, then to undefined
    access("R6", 1'b0, 2'd1, 32'h0, 1'b0, 0, 0, 0, 0, 1, 1'b0);
    access("R6", 1'b0, 2'd1, 32'h0, 1'b1, 1, 0, 1, 0, 1, 1'b0);
    access("R6", 1'b0, 2'd1, 32'h0, 1'b0, 0, 0, 0, 0, 0, 1'b0);
    idle_check();

    // R10: random traffic, all rules
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if ($urandom_range(0, 7) == 0) idle_check();
      access("R10", r[0], {r[2], r[1]}, $urandom, r[3], r[4], r[5], r[6],
             r[7], 1'($urandom), 1'($urandom));
    end
    idle_check();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule